// File: doc/BRIEF.md
# Actuator Startup and Move Sequencer

This block decides when an external drive-waveform generator runs, in which direction it pushes a piezo actuator, and for how many waveform periods. It does not shape waveforms and holds no configuration registers. It reads a step length, homing settings and move commands from neighbouring logic. It counts the end-of-period pulses the generator returns. One step is a programmable whole number of periods.

A rising edge on `enable` can start a homing sequence when the homing-disable bit is clear. The sequence drives toward a chosen end stop. It then idles for four steps with the output stage off and swings back the opposite way by an encoded number of steps. Move commands add to or replace a pending step count. The pending steps run in the commanded direction as soon as the sequencer is free. A command that arrives during homing waits until the swing-back ends. `busy` is high through every active phase. Dropping `enable` stops everything in the same cycle. A test input forces endless motion toward infinity.

Top module: `actuator_move_seq`

## Requirements
- R1: After reset `busy`, `gen_run` and `drive_en` are 0.
- R2: One step is `step_len`+1 counted `period_done` pulses, giving 1 to 256 periods per step.
- R3: Homing starts on a 0-to-1 transition of `enable` only when `home_skip` is 0. With `home_skip` = 1 that transition starts no homing.
- R4: The homing drive phase lasts 16×(`home_code`+1) steps (16 to 256). `drive_dir` equals `home_dir` during it, where 0 means toward infinity and 1 means toward macro.
- R5: After the drive phase, a wait phase of exactly 4 steps follows. During it `gen_run`=1, `drive_en`=0 and `busy`=1.
- R6: The swing-back phase runs in the direction opposite to `home_dir`. Its length follows `back_code`: 0→2, 1→1, 2→3, 3→4 steps. After it `busy` falls unless steps are pending.
- R7: A move command (`cmd_valid` pulse) with a nonzero count while idle makes `busy`=1 and `drive_dir`=`cmd_dir` two clocks later. The move runs the pending number of steps, then `busy` returns to 0.
- R8: A command in the pending direction adds its count, saturating at 512 steps. A command in the other direction replaces the count and direction. A pending count of 0 ends a move.
- R9: Commands received during homing are held and run directly after the swing-back, with no idle cycle. Commands received while `enable` is 0 are held and run once `enable` rises.
- R10: While `enable` is 0, `busy`, `gen_run` and `drive_en` are 0 in the same cycle. The clock edge at which `enable` is first seen low clears the pending count.
- R11: While `enable` and `cont_test` are both 1, the block drives continuously toward infinity (`drive_dir`=0, `busy`=1) regardless of `period_done`. When `cont_test` drops it returns to idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| enable | input | 1 | Run enable; a rising edge may start homing |
| period_done | input | 1 | One-cycle pulse at the end of each generator period |
| step_len | input | 8 | Periods per step minus one |
| home_skip | input | 1 | 1 disables homing on enable rise |
| home_dir | input | 1 | Homing drive direction (0 infinity, 1 macro) |
| home_code | input | 4 | Homing drive length code |
| back_code | input | 2 | Swing-back length code |
| cmd_valid | input | 1 | Move command write complete (one-cycle pulse) |
| cmd_count | input | 7 | Steps carried by the command |
| cmd_dir | input | 1 | Command direction (0 infinity, 1 macro) |
| cont_test | input | 1 | Test: continuous drive toward infinity |
| gen_run | output | 1 | Generator should keep producing periods |
| drive_en | output | 1 | Output stage drives the actuator |
| drive_dir | output | 1 | Drive direction (0 infinity, 1 macro) |
| busy | output | 1 | Sequencer active |

## Verification
Each `period_done` pulse registers on one rising edge. The phase it completes shows on the outputs at the falling edge after that edge. The bench therefore issues pulses on falling edges and samples one falling edge later, and it counts pulses until `busy` falls to compare whole phase lengths. A move command shows on `busy` two edges after `cmd_valid`: one edge loads the pending count and the next moves the state. A switch to a zero count likewise ends motion two edges later. The enable abort is combinational, so it is sampled one nanosecond after `enable` falls, with no clock edge in between.

// File: rtl/ams_pkg.sv
package ams_pkg;
  typedef enum logic [2:0] {
    ST_IDLE  = 3'd0,
    ST_HDRV  = 3'd1,
    ST_HWAIT = 3'd2,
    ST_HBACK = 3'd3,
    ST_MOVE  = 3'd4,
    ST_CONT  = 3'd5
  } ams_state_e;

  localparam int unsigned WAIT_STEPS = 4;

  function automatic logic [2:0] back_steps(input logic [1:0] code);
    case (code)
      2'd0:    back_steps = 3'd2;
      2'd1:    back_steps = 3'd1;
      2'd2:    back_steps = 3'd3;
      default: back_steps = 3'd4;
    endcase
  endfunction
endpackage

// File: rtl/ams_period_div.sv
module ams_period_div #(
  parameter int unsigned STEP_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clr,
  input  logic              run,
  input  logic              period_done,
  input  logic [STEP_W-1:0] step_len,
  output logic              step_tick
);
  logic [STEP_W-1:0] per_q, per_d;
  logic              at_end;

  assign at_end    = (per_q >= step_len);
  assign step_tick = run && period_done && at_end;

  always_comb begin
    per_d = per_q;
    if (clr) begin
      per_d = '0;
    end else if (run && period_done) begin
      per_d = at_end ? '0 : per_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) per_q <= '0;
    else        per_q <= per_d;
  end

  // R2
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!run && !clr) |=> $stable(per_q));
endmodule

// File: rtl/ams_pending.sv
module ams_pending #(
  parameter int unsigned CNT_W    = 7,
  parameter int unsigned PEND_MAX = 512,
  localparam int unsigned PEND_W  = $clog2(PEND_MAX + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic             cmd_valid,
  input  logic [CNT_W-1:0] cmd_count,
  input  logic             cmd_dir,
  input  logic             consume,
  output logic             pend_nz,
  output logic             pend_last,
  output logic             pend_dir
);
  logic [PEND_W-1:0] cnt_q, cnt_d;
  logic              dir_q, dir_d;
  logic [PEND_W-1:0] base;
  logic [PEND_W:0]   sum;

  assign pend_nz   = (cnt_q != '0);
  assign pend_last = (cnt_q == PEND_W'(1));
  assign pend_dir  = dir_q;

  always_comb begin
    base  = (consume && pend_nz) ? cnt_q - 1'b1 : cnt_q;
    sum   = {1'b0, base} + (PEND_W + 1)'(cmd_count);
    cnt_d = cnt_q;
    dir_d = dir_q;
    if (clr) begin
      cnt_d = '0;
    end else if (cmd_valid && (cmd_dir != dir_q)) begin
      cnt_d = PEND_W'(cmd_count);
      dir_d = cmd_dir;
    end else if (cmd_valid) begin
      cnt_d = (sum > (PEND_W + 1)'(PEND_MAX)) ? PEND_W'(PEND_MAX) : sum[PEND_W-1:0];
    end else begin
      cnt_d = base;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      dir_q <= 1'b0;
    end else begin
      cnt_q <= cnt_d;
      dir_q <= dir_d;
    end
  end

  // R8
  pend_sat_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= PEND_W'(PEND_MAX));

  // R8
  dir_replace_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && !clr && (cmd_dir != dir_q)) |=>
      (cnt_q == PEND_W'($past(cmd_count)) && dir_q == $past(cmd_dir)));
endmodule

// File: rtl/ams_phase_fsm.sv
module ams_phase_fsm
  import ams_pkg::*;
#(
  parameter int unsigned CODE_W = 4,
  localparam int unsigned PH_W  = CODE_W + 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              enable,
  input  logic              en_rise,
  input  logic              home_skip,
  input  logic              home_dir,
  input  logic [CODE_W-1:0] home_code,
  input  logic [1:0]        back_code,
  input  logic              cont_test,
  input  logic              step_tick,
  input  logic              pend_nz,
  input  logic              pend_last,
  input  logic              pend_dir,
  output logic              consume,
  output logic              per_clr,
  output logic              gen_run,
  output logic              drive_en,
  output logic              drive_dir,
  output logic              busy
);
  ams_state_e      st_q, st_d;
  logic [PH_W-1:0] ph_q, ph_d;
  logic            hdir_q, hdir_d;
  logic [PH_W-1:0] target;
  logic            homing;
  logic            last_step;
  logic            active;

  assign homing = (st_q == ST_HDRV) || (st_q == ST_HWAIT) || (st_q == ST_HBACK);

  always_comb begin
    case (st_q)
      ST_HDRV:  target = (PH_W'(home_code) + PH_W'(1)) << 4;
      ST_HWAIT: target = PH_W'(WAIT_STEPS);
      ST_HBACK: target = PH_W'(back_steps(back_code));
      default:  target = PH_W'(1);
    endcase
  end

  assign last_step = step_tick && (ph_q == target - PH_W'(1));

  always_comb begin
    st_d   = st_q;
    hdir_d = hdir_q;
    if (!enable) begin
      st_d = ST_IDLE;
    end else if (cont_test) begin
      st_d = ST_CONT;
    end else begin
      case (st_q)
        ST_IDLE, ST_CONT: begin
          if (en_rise && !home_skip) begin
            st_d   = ST_HDRV;
            hdir_d = home_dir;
          end else if (pend_nz) begin
            st_d = ST_MOVE;
          end else begin
            st_d = ST_IDLE;
          end
        end
        ST_HDRV:  if (last_step) st_d = ST_HWAIT;
        ST_HWAIT: if (last_step) st_d = ST_HBACK;
        ST_HBACK: if (last_step) st_d = pend_nz ? ST_MOVE : ST_IDLE;
        ST_MOVE: begin
          if (!pend_nz || (step_tick && pend_last)) st_d = ST_IDLE;
        end
        default: st_d = ST_IDLE;
      endcase
    end
  end

  assign per_clr = (st_d != st_q);

  always_comb begin
    ph_d = ph_q;
    if (st_d != st_q) begin
      ph_d = '0;
    end else if (homing && step_tick) begin
      ph_d = ph_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= ST_IDLE;
      ph_q   <= '0;
      hdir_q <= 1'b0;
    end else begin
      st_q   <= st_d;
      ph_q   <= ph_d;
      hdir_q <= hdir_d;
    end
  end

  assign active   = enable && (st_q != ST_IDLE);
  assign busy     = active;
  assign gen_run  = active;
  assign drive_en = active && (st_q != ST_HWAIT);
  assign consume  = enable && !cont_test && (st_q == ST_MOVE) && step_tick;

  always_comb begin
    case (st_q)
      ST_HDRV:  drive_dir = hdir_q;
      ST_HBACK: drive_dir = !hdir_q;
      ST_MOVE:  drive_dir = pend_dir;
      default:  drive_dir = 1'b0;
    endcase
  end

  // R4
  ph_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    homing |-> (ph_q < target));

  // R7
  move_entry_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((st_q == ST_MOVE) && ($past(st_q) != ST_MOVE)) |-> $past(pend_nz));

  // R11
  cont_dir_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (enable && cont_test) |=> (!enable || !cont_test || (busy && !drive_dir)));
endmodule

// File: rtl/actuator_move_seq.sv
module actuator_move_seq #(
  parameter int unsigned STEP_W   = 8,
  parameter int unsigned CODE_W   = 4,
  parameter int unsigned CNT_W    = 7,
  parameter int unsigned PEND_MAX = 512
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              enable,
  input  logic              period_done,
  input  logic [STEP_W-1:0] step_len,
  input  logic              home_skip,
  input  logic              home_dir,
  input  logic [CODE_W-1:0] home_code,
  input  logic [1:0]        back_code,
  input  logic              cmd_valid,
  input  logic [CNT_W-1:0]  cmd_count,
  input  logic              cmd_dir,
  input  logic              cont_test,
  output logic              gen_run,
  output logic              drive_en,
  output logic              drive_dir,
  output logic              busy
);
  logic en_q;
  logic en_rise, en_fall;
  logic step_tick, per_clr, consume;
  logic pend_nz, pend_last, pend_dir;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) en_q <= 1'b0;
    else        en_q <= enable;
  end

  assign en_rise = enable && !en_q;
  assign en_fall = !enable && en_q;

  ams_period_div #(.STEP_W(STEP_W)) div_i (
    .clk         (clk),
    .rst_n       (rst_n),
    .clr         (per_clr),
    .run         (gen_run),
    .period_done (period_done),
    .step_len    (step_len),
    .step_tick   (step_tick)
  );

  ams_pending #(.CNT_W(CNT_W), .PEND_MAX(PEND_MAX)) pend_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .clr       (en_fall),
    .cmd_valid (cmd_valid),
    .cmd_count (cmd_count),
    .cmd_dir   (cmd_dir),
    .consume   (consume),
    .pend_nz   (pend_nz),
    .pend_last (pend_last),
    .pend_dir  (pend_dir)
  );

  ams_phase_fsm #(.CODE_W(CODE_W)) fsm_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .enable    (enable),
    .en_rise   (en_rise),
    .home_skip (home_skip),
    .home_dir  (home_dir),
    .home_code (home_code),
    .back_code (back_code),
    .cont_test (cont_test),
    .step_tick (step_tick),
    .pend_nz   (pend_nz),
    .pend_last (pend_last),
    .pend_dir  (pend_dir),
    .consume   (consume),
    .per_clr   (per_clr),
    .gen_run   (gen_run),
    .drive_en  (drive_en),
    .drive_dir (drive_dir),
    .busy      (busy)
  );

  // R10
  disabled_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !enable |-> (!busy && !gen_run && !drive_en));
endmodule

// File: tb/actuator_move_seq_tb_top.sv
`timescale 1ns/1ps
module actuator_move_seq_tb_top;
  logic       clk = 1'b0;
  logic       rst_n;
  logic       enable, period_done, home_skip, home_dir, cmd_valid, cmd_dir, cont_test;
  logic [7:0] step_len;
  logic [3:0] home_code;
  logic [1:0] back_code;
  logic [6:0] cmd_count;
  logic       gen_run, drive_en, drive_dir, busy;

  int n_chk  = 0;
  int n_fail = 0;
  bit done   = 1'b0;

  always #5 clk = ~clk;

  actuator_move_seq dut_i (
    .clk(clk), .rst_n(rst_n), .enable(enable), .period_done(period_done),
    .step_len(step_len), .home_skip(home_skip), .home_dir(home_dir),
    .home_code(home_code), .back_code(back_code), .cmd_valid(cmd_valid),
    .cmd_count(cmd_count), .cmd_dir(cmd_dir), .cont_test(cont_test),
    .gen_run(gen_run), .drive_en(drive_en), .drive_dir(drive_dir), .busy(busy)
  );

  task automatic check(input string tag, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic tick();
    @(negedge clk);
  endtask

  task automatic pulse(input int n);
    for (int i = 0; i < n; i++) begin
      period_done = 1'b1;
      tick();
      period_done = 1'b0;
    end
  endtask

  task automatic send_cmd(input int cnt, input bit dir);
    cmd_count = 7'(cnt);
    cmd_dir   = dir;
    cmd_valid = 1'b1;
    tick();
    cmd_valid = 1'b0;
  endtask

  task automatic run_to_idle(output int n);
    n = 0;
    while (busy && n < 2000) begin
      pulse(1);
      n++;
    end
  endtask

  task automatic report();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  endtask

  task automatic t_reset();
    check("R1 busy", busy, 0);
    check("R1 gen_run", gen_run, 0);
    check("R1 drive_en", drive_en, 0);
  endtask

  task automatic t_home_detail();
    step_len = 8'd1; home_code = 4'd0; back_code = 2'd0; home_dir = 1'b1; home_skip = 1'b0;
    enable = 1'b1; tick();
    check("R3 busy after rise", busy, 1);
    check("R4 dir macro", drive_dir, 1);
    pulse(31);
    check("R2 R4 still driving at 31 periods", drive_en, 1);
    pulse(1);
    check("R5 wait drive_en", drive_en, 0);
    check("R5 wait busy", busy, 1);
    check("R5 wait gen_run", gen_run, 1);
    pulse(7);
    check("R5 wait lasts 4 steps", drive_en, 0);
    pulse(1);
    check("R6 swing drive_en", drive_en, 1);
    check("R6 swing opposite dir", drive_dir, 0);
    pulse(3);
    check("R6 swing busy", busy, 1);
    pulse(1);
    check("R6 idle after swing", busy, 0);
    enable = 1'b0; tick();
  endtask

  task automatic t_back_codes();
    int n;
    step_len = 8'd0; home_code = 4'd0; home_skip = 1'b0; home_dir = 1'b0;
    for (int c = 0; c < 4; c++) begin
      int exp_back;
      exp_back = (c == 0) ? 2 : (c == 1) ? 1 : (c == 2) ? 3 : 4;
      back_code = 2'(c);
      enable = 1'b1; tick();
      run_to_idle(n);
      check($sformatf("R6 back code %0d", c), n, 20 + exp_back);
      enable = 1'b0; tick();
    end
    home_code = 4'd15; back_code = 2'd1;
    enable = 1'b1; tick();
    run_to_idle(n);
    check("R4 longest homing", n, 256 + 4 + 1);
    enable = 1'b0; tick();
  endtask

  task automatic t_skip();
    home_skip = 1'b1;
    enable = 1'b1; tick(); tick();
    check("R3 skip gives no homing", busy, 0);
  endtask

  task automatic t_move();
    int n;
    step_len = 8'd2;
    send_cmd(3, 1'b1);
    tick();
    check("R7 busy two clocks after cmd", busy, 1);
    check("R7 dir", drive_dir, 1);
    run_to_idle(n);
    check("R2 R7 3 steps of 3 periods", n, 9);
    check("R7 idle after move", busy, 0);
  endtask

  task automatic t_accum_switch();
    int n;
    step_len = 8'd0;
    send_cmd(2, 1'b0); tick();
    send_cmd(3, 1'b0);
    run_to_idle(n);
    check("R8 same dir adds", n, 5);
    send_cmd(5, 1'b1); tick();
    pulse(1);
    send_cmd(0, 1'b0); tick();
    check("R8 zero switch stops", busy, 0);
    send_cmd(5, 1'b1); tick();
    send_cmd(2, 1'b0);
    check("R8 switch dir", drive_dir, 0);
    run_to_idle(n);
    check("R8 switch replaces count", n, 2);
  endtask

  task automatic t_held_saturate();
    int n;
    enable = 1'b0; tick();
    for (int i = 0; i < 5; i++) send_cmd(127, 1'b1);
    check("R9 no motion while disabled", busy, 0);
    home_skip = 1'b1; step_len = 8'd0;
    enable = 1'b1; tick();
    check("R9 held cmd runs on enable", busy, 1);
    run_to_idle(n);
    check("R8 saturates at 512", n, 512);
  endtask

  task automatic t_abort();
    send_cmd(10, 1'b0); tick();
    pulse(2);
    enable = 1'b0; #1;
    check("R10 busy drops at once", busy, 0);
    check("R10 drive_en drops", drive_en, 0);
    check("R10 gen_run drops", gen_run, 0);
    tick();
    enable = 1'b1; tick(); tick();
    check("R10 pending cleared", busy, 0);
  endtask

  task automatic t_held_homing();
    int n;
    enable = 1'b0; tick();
    home_skip = 1'b0; home_dir = 1'b1; home_code = 4'd0; back_code = 2'd0; step_len = 8'd0;
    enable = 1'b1; tick();
    pulse(3);
    send_cmd(2, 1'b1);
    check("R9 homing continues", drive_dir, 1);
    pulse(19);
    check("R9 move follows swing at once", busy, 1);
    check("R9 move dir", drive_dir, 1);
    run_to_idle(n);
    check("R9 held steps", n, 2);
  endtask

  task automatic t_cont();
    home_skip = 1'b1;
    cont_test = 1'b1; tick();
    check("R11 busy", busy, 1);
    check("R11 dir infinity", drive_dir, 0);
    check("R11 drive_en", drive_en, 1);
    pulse(300);
    check("R11 still running", busy, 1);
    cont_test = 1'b0; tick();
    check("R11 stops when released", busy, 0);
  endtask

  initial begin
    rst_n = 1'b0; enable = 1'b0; period_done = 1'b0; home_skip = 1'b0; home_dir = 1'b0;
    cmd_valid = 1'b0; cmd_dir = 1'b0; cmd_count = '0; cont_test = 1'b0;
    step_len = '0; home_code = '0; back_code = '0;
    tick(); tick();
    rst_n = 1'b1;
    tick();
    t_reset();
    t_home_detail();
    t_back_codes();
    t_skip();
    t_move();
    t_accum_switch();
    t_held_saturate();
    t_abort();
    t_held_homing();
    t_cont();
    done = 1'b1;
    report();
  end

  initial begin
    #1_500_000;
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual hung expected finish");
      report();
    end
  end
endmodule